// File: doc/BRIEF.md
# Event-to-Task Routing Matrix

This block lets peripherals trigger each other directly, with no processor in the path. It takes a vector of single-cycle event pulses, one line for each event identifier. It returns a vector of single-cycle task pulses, one line for each task identifier. Between the two sit a number of programmable channels. Each channel holds one event identifier and one task identifier. When a channel is enabled and its event pulses, it raises its task line on the next clock.

Software sets up the matrix through a plain register port, with a write strobe, an address, write data and combinational read data. Each channel has two identifier registers, one for the event and one for the task. Channel enables are packed into 32-bit words. A set word turns channels on and a clear word turns them off. A status word reads back the current enable state. The pulse vectors are plain signals, because a pulse cannot be held back. There is therefore no valid/ready handshake and no back-pressure on either side: every pulse presented is acted on in the cycle it is sampled.

Top module: `evt_task_matrix`

## Requirements
- R1: After reset every channel is disabled, every status word and identifier register reads 0, and no task line pulses.
- R2: For channel c, the event identifier lives at address 0x40+2c and the task identifier at 0x41+2c. Each holds bits [7:0] of the written data and reads back zero-extended. Upper data bits are discarded.
- R3: A write to the set word at address 0x00+w enables each channel whose bit is 1, where channel c is bit c mod 32 of word c/32. Bits written as 0 leave their channels unchanged.
- R4: A write to the clear word at address 0x04+w disables each channel whose bit is 1, using the same bit layout. Bits written as 0 leave their channels unchanged.
- R5: The status word at address 0x08+w reads the enable state of its channels in the same bit layout. Bits with no channel behind them (word 1, bits 31:18) read 0.
- R6: When an enabled channel with event ID e and task ID t sees evt_i[e] high on a clock edge, task_o[t] is high for exactly the one following cycle.
- R7: A disabled channel never causes a task pulse, whatever its event line does.
- R8: Identifier 0 means "none". A channel whose event ID or task ID is 0 never fires, and task_o[0] never pulses.
- R9: Channels that hit the same task in one cycle merge into a single pulse on that line. Channels that hit different tasks pulse their lines together.
- R10: An enable write takes effect from the clock edge that captures it. An event sampled on that same edge is judged by the enable state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| evt_i | input | 256 | Event pulse lines, indexed by event ID |
| task_o | output | 256 | Registered task pulse lines, indexed by task ID |

## Verification
Two functions of this block can meet in one cycle: an enable write (set or clear) and an event pulse for the channel being written. The bench provokes this by presenting the event in the very cycle it writes the clear word, and later in the cycle it writes the set word. The pulse must follow the old enable state, so it is present after the clear and absent after the set. The bench then repeats the event one cycle later to confirm that the new state has taken hold. A second overlap, two channels striking the same task line in one cycle, is judged by requiring a single merged pulse on that line.

// File: rtl/evt_task_matrix_pkg.sv
package evt_task_matrix_pkg;
  localparam int ID_W   = 8;
  localparam int NUM_ID = 1 << ID_W;

  // register word addresses
  localparam int SET_BASE  = 'h00;
  localparam int CLR_BASE  = 'h04;
  localparam int STAT_BASE = 'h08;
  localparam int CH_BASE   = 'h40;

  typedef logic [ID_W-1:0] id_t;

  typedef struct packed {
    id_t evt_id;
    id_t task_id;
  } route_t;
endpackage

// File: rtl/etm_route_regs.sv
module etm_route_regs
  import evt_task_matrix_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  id_t                     wid,
  output route_t [NUM_CH-1:0]     routes_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] EVT_ADR  = ADDR_W'(CH_BASE + 2*c);
    localparam logic [ADDR_W-1:0] TASK_ADR = ADDR_W'(CH_BASE + 2*c + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        routes_o[c] <= '0;
      end else if (we) begin
        if (addr == EVT_ADR)  routes_o[c].evt_id  <= wid;
        if (addr == TASK_ADR) routes_o[c].task_id <= wid;
      end
    end
  end
endmodule

// File: rtl/etm_enable_bank.sv
module etm_enable_bank
  import evt_task_matrix_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] en_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
    localparam int WORD = c / DATA_W;
    localparam int BIT  = c % DATA_W;
    localparam logic [ADDR_W-1:0] SET_ADR = ADDR_W'(SET_BASE + WORD);
    localparam logic [ADDR_W-1:0] CLR_ADR = ADDR_W'(CLR_BASE + WORD);

    logic set_hit, clr_hit;
    assign set_hit = we && (addr == SET_ADR) && wdata[BIT];
    assign clr_hit = we && (addr == CLR_ADR) && wdata[BIT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_o[c] <= 1'b0;
      else if (set_hit) en_o[c] <= 1'b1;
      else if (clr_hit) en_o[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/etm_route_core.sv
module etm_route_core
  import evt_task_matrix_pkg::*;
#(
  parameter int NUM_CH = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   en_i,
  input  route_t [NUM_CH-1:0] routes_i,
  input  logic [NUM_ID-1:0]   evt_i,
  output logic [NUM_ID-1:0]   task_o
);
  logic [NUM_CH-1:0] hit;
  logic [NUM_ID-1:0] fire_nx;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign hit[c] = en_i[c]
                 && (routes_i[c].evt_id  != '0)
                 && (routes_i[c].task_id != '0)
                 && evt_i[routes_i[c].evt_id];
  end

  // several channels on one task line collapse into one pulse
  always_comb begin
    fire_nx = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c]) fire_nx[routes_i[c].task_id] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) task_o <= '0;
    else        task_o <= fire_nx;
  end
endmodule

// File: rtl/evt_task_matrix.sv
module evt_task_matrix
  import evt_task_matrix_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [NUM_ID-1:0] evt_i,
  output logic [NUM_ID-1:0] task_o
);
  localparam int NUM_WORDS = (NUM_CH + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_WORDS * DATA_W;

  logic [NUM_CH-1:0]   en_q;
  route_t [NUM_CH-1:0] routes;
  logic [PAD_W-1:0]    en_pad;

  etm_route_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wid      (cfg_wdata[ID_W-1:0]),
    .routes_o (routes)
  );

  etm_enable_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .en_o  (en_q)
  );

  etm_route_core #(.NUM_CH(NUM_CH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_q),
    .routes_i (routes),
    .evt_i    (evt_i),
    .task_o   (task_o)
  );

  assign en_pad = PAD_W'(en_q);

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (cfg_addr == ADDR_W'(STAT_BASE + w)) cfg_rdata = en_pad[w*DATA_W +: DATA_W];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (cfg_addr == ADDR_W'(CH_BASE + 2*c))     cfg_rdata = DATA_W'(routes[c].evt_id);
      if (cfg_addr == ADDR_W'(CH_BASE + 2*c + 1)) cfg_rdata = DATA_W'(routes[c].task_id);
    end
  end
endmodule

// File: rtl/evt_task_matrix_chk.sv
module evt_task_matrix_chk
  import evt_task_matrix_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NUM_ID-1:0] evt_i,
  input logic [NUM_ID-1:0] task_o,
  input logic [NUM_CH-1:0] en
);
  localparam int NUM_WORDS = (NUM_CH + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_WORDS * DATA_W;

  logic [PAD_W-1:0] en_pad;
  assign en_pad = PAD_W'(en);

  function automatic logic [DATA_W-1:0] word_mask(int w);
    logic [DATA_W-1:0] m = '0;
    for (int b = 0; b < DATA_W; b++) if (w*DATA_W + b < NUM_CH) m[b] = 1'b1;
    return m;
  endfunction

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
    localparam logic [DATA_W-1:0] MSK = word_mask(w);

    assert_set_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(SET_BASE + w)) |=>
      ((en_pad[w*DATA_W +: DATA_W] & $past(wdata) & MSK) == ($past(wdata) & MSK)));

    assert_clr_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(CLR_BASE + w)) |=>
      ((en_pad[w*DATA_W +: DATA_W] & $past(wdata)) == '0));
  end

  assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en == '0 && task_o == '0));

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (task_o != '0) |-> ($past(evt_i) != '0));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> (task_o == '0));

  assert_task_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    task_o[0] == 1'b0);

  assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en));
endmodule

bind evt_task_matrix evt_task_matrix_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .we     (cfg_we),
  .addr   (cfg_addr),
  .wdata  (cfg_wdata),
  .evt_i  (evt_i),
  .task_o (task_o),
  .en     (en_q)
);

// File: tb/evt_task_matrix_test.sv
`timescale 1ns/1ps
module evt_task_matrix_test;
  localparam int NCH  = 50;
  localparam int NID  = 256;
  localparam int PER  = 4;
  localparam logic [7:0] SET0 = 8'h00, SET1 = 8'h01, CLR0 = 8'h04, CLR1 = 8'h05,
                         STAT0 = 8'h08, STAT1 = 8'h09;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NID-1:0] evt_i = '0;
  logic [NID-1:0] task_o;

  int checks = 0;
  int fails  = 0;

  logic [NID-1:0] exp_q[$];
  string          tag_q[$];

  logic       m_en[NCH];
  logic [7:0] m_ev[NCH];
  logic [7:0] m_tk[NCH];

  always #(PER/2) clk = ~clk;

  evt_task_matrix uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_i(evt_i), .task_o(task_o)
  );

  function automatic logic [NID-1:0] ev1(int id);
    return NID'(1) << id;
  endfunction

  function automatic logic [NID-1:0] model_fire(logic [NID-1:0] ev);
    logic [NID-1:0] r = '0;
    for (int c = 0; c < NCH; c++)
      if (m_en[c] && m_ev[c] != 0 && m_tk[c] != 0 && ev[m_ev[c]]) r[m_tk[c]] = 1'b1;
    return r;
  endfunction

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    for (int c = 0; c < NCH; c++) begin
      if (a == 8'(SET0 + c/32) && d[c%32]) m_en[c] = 1'b1;
      if (a == 8'(CLR0 + c/32) && d[c%32]) m_en[c] = 1'b0;
      if (a == 8'(8'h40 + 2*c))     m_ev[c] = d[7:0];
      if (a == 8'(8'h40 + 2*c + 1)) m_tk[c] = d[7:0];
    end
  endtask

  // driver: one call per clock cycle, pushes what task_o must show next cycle
  task automatic step(logic [NID-1:0] ev, logic w, logic [7:0] a, logic [31:0] d, string tag);
    @(posedge clk); #1;
    evt_i = ev; cfg_we = w; cfg_addr = a; cfg_wdata = d;
    exp_q.push_back(model_fire(ev));
    tag_q.push_back(tag);
    if (w) model_write(a, d);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    step('0, 1'b1, a, d, tag);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    step('0, 1'b0, a, '0, tag);
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      fails++;
      $display("FAIL %s rdata@%h actual=%h expected=%h", tag, a, cfg_rdata, exp);
    end
  endtask

  // monitor: compares the item whose effect is visible in this cycle
  always @(negedge clk) begin
    if (rst_n && exp_q.size() >= 2) begin
      logic [NID-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (task_o !== e) begin
        fails++;
        $display("FAIL %s task_o actual=%h expected=%h", t, task_o, e);
      end
    end
  end

  initial begin
    #(PER * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_en[c] = 0; m_ev[c] = 0; m_tk[c] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(STAT0, 0, "R1");
    rd(STAT1, 0, "R1");
    rd(8'h40, 0, "R1");
    rd(8'hA3, 0, "R1");
    step(ev1(5), 0, 0, 0, "R1");

    // R2 identifier registers
    wr(8'h40, 5, "R2");
    wr(8'h41, 9, "R2");
    rd(8'h40, 5, "R2");
    rd(8'h41, 9, "R2");
    wr(8'h42, 32'h0000_01A3, "R2");
    rd(8'h42, 32'h0000_00A3, "R2");

    // R7 disabled channel stays quiet
    step(ev1(5), 0, 0, 0, "R7");
    step('0, 0, 0, 0, "R7");

    // R3 set, R6 fire one cycle later for one cycle
    wr(SET0, 1, "R3");
    rd(STAT0, 1, "R3");
    step(ev1(5), 0, 0, 0, "R6");
    step('0, 0, 0, 0, "R6");
    wr(SET0, 32'h4, "R3");
    rd(STAT0, 32'h5, "R3");

    // R9 merge and parallel tasks
    wr(8'h44, 5, "R9");
    wr(8'h45, 9, "R9");
    wr(8'h46, 7, "R9");
    wr(8'h47, 11, "R9");
    wr(SET0, 32'h8, "R9");
    rd(STAT0, 32'hD, "R9");
    step(ev1(5) | ev1(7), 0, 0, 0, "R9");
    step(ev1(7), 0, 0, 0, "R9");
    step('0, 0, 0, 0, "R9");

    // second enable word, R5 status layout
    wr(8'hA2, 200, "R6");
    wr(8'hA3, 250, "R6");
    wr(SET1, 32'h0002_0000, "R3");
    rd(STAT1, 32'h0002_0000, "R5");
    step(ev1(200), 0, 0, 0, "R6");
    wr(SET1, 32'hFFFF_FFFF, "R5");
    rd(STAT1, 32'h0003_FFFF, "R5");
    wr(CLR1, 32'hFFFF_FFFF, "R4");
    rd(STAT1, 0, "R4");
    step(ev1(200), 0, 0, 0, "R7");

    // R4 zero bits ignored, then selective clear
    wr(CLR0, 0, "R4");
    rd(STAT0, 32'hD, "R4");
    wr(CLR0, 32'hC, "R4");
    rd(STAT0, 1, "R4");

    // R10 write and event in the same cycle
    step(ev1(5), 1, CLR0, 1, "R10");
    step(ev1(5), 0, 0, 0, "R10");
    rd(STAT0, 0, "R10");
    step(ev1(5), 1, SET0, 1, "R10");
    step(ev1(5), 0, 0, 0, "R10");
    step('0, 0, 0, 0, "R10");

    // R8 identifier zero means none
    wr(8'h48, 0, "R8");
    wr(8'h49, 12, "R8");
    wr(8'h4A, 6, "R8");
    wr(8'h4B, 0, "R8");
    wr(8'h4C, 6, "R8");
    wr(8'h4D, 13, "R8");
    wr(SET0, 32'h70, "R8");
    rd(STAT0, 32'h71, "R8");
    step(ev1(0) | ev1(6), 0, 0, 0, "R8");
    step(ev1(0), 0, 0, 0, "R8");

    repeat (3) step('0, 0, 0, 0, "R6");
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule